// File: doc/BRIEF.md
# Banked Partial-Product Tap Multiplier

This block is the multiplier inside one tap of an adaptive filter. The tap coefficient changes at run time, but it stays fixed for many samples in a row. The block does not use a general multiplier. It keeps a small table of precomputed coefficient multiples and splits the signed input into 3-bit digits. It looks up one partial product per digit and adds the shifted partial products, least significant digit first, to form the exact signed product.

Each table address is a digit joined to a sign-control bit. The control bit is set only for the most significant digit, so in that position the table returns negative multiples and the top digit acts as a two's-complement sign digit. Two tables are kept. One serves multiplies while the other is refilled, one entry per clock, after a coefficient load request. When the refill completes, the tables swap roles. The 16-cycle reload therefore never stalls the multiply path.

A user writes a coefficient by pulsing `coef_load` and starts a multiply by pulsing `mul_start`. The product appears together with a one-cycle `mul_done` pulse. `read_bank` shows which table is currently serving multiplies.

Top module: `pp_mult_tap`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `product` is 0, `mul_done` is low, `reload_busy` is low and `read_bank` is 0.
- R2: A `coef_load` pulse accepted while idle holds `reload_busy` high for exactly 16 cycles, during which the table not selected by `read_bank` is written. `read_bank` inverts on the same edge that `reload_busy` falls, and at no other time.
- R3: Table entry at address {ctl, d}, where ctl is bit 3 and d is the 3-bit digit in bits 2:0, holds d·C when ctl is 0. When ctl is 1, it holds d·C for d in 0..3 and (d−8)·C for d in 4..7. The worked case 5 × (−182) gives −910.
- R4: `product` equals the exact two's-complement product of the signed 12-bit `data_in` and the signed 12-bit coefficient of the serving table, for every value including −2048 for either operand.
- R5: A multiply accepted at a clock edge raises `mul_done` for exactly one cycle, five edges later (digit count plus one). `product` changes only on that edge and holds its value until the next completion.
- R6: A multiply uses the table that `read_bank` selected when the multiply was accepted, even if a reload completes and inverts `read_bank` before the multiply finishes.
- R7: A `mul_start` that arrives while a multiply is in progress, from its acceptance to its completion edge, is ignored.
- R8: A `coef_load` is ignored while a reload is in progress. It is also ignored while a multiply in progress reads the table that the reload would write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coef_in | input | 12 | Signed coefficient captured with `coef_load` |
| coef_load | input | 1 | Request to refill the idle table with `coef_in` |
| mul_start | input | 1 | Request to multiply `data_in` |
| data_in | input | 12 | Signed multiplicand captured with `mul_start` |
| product | output | 24 | Signed product, registered |
| mul_done | output | 1 | One-cycle pulse when `product` is updated |
| read_bank | output | 1 | Index of the table serving multiplies |
| reload_busy | output | 1 | High while a table refill is running |

## Verification
The bench builds the block with its default 12-bit input, 12-bit coefficient and 24-bit product. At that size the input splits into four digits, and the top digit exercises the sign-control half of the table. This size also lets the bench drive both extreme negative operands and the full positive range, and compare the results against a plain integer product. A reference model tracks reload timing, bank swaps and in-flight multiplies. This lets the bench time a multiply to straddle a bank swap and time a load into the conflict window, and then predict exactly which coefficient each product must use.

// File: rtl/pp_tap_pkg.sv
package pp_tap_pkg;
  localparam int DIGIT_W = 3;
  localparam int BANKS   = 2;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;

  function automatic int digits_for(input int width);
    return (width + DIGIT_W - 1) / DIGIT_W;
  endfunction
endpackage

// File: rtl/pp_table_filler.sv
module pp_table_filler
  import pp_tap_pkg::*;
#(
  parameter int COEF_W = 12,
  parameter int ENT_W  = COEF_W + DIGIT_W + 1,
  parameter int ADDR_W = DIGIT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_req,
  input  logic signed [COEF_W-1:0] coef_in,
  output logic                     wr_en,
  output logic                     wr_bank,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic signed [ENT_W-1:0]  wr_data,
  output logic                     read_bank,
  output logic                     busy
);
  localparam int ENTRIES = 2 ** ADDR_W;
  localparam int MULT_W  = DIGIT_W + 2;

  fill_state_e               state;
  logic [ADDR_W-1:0]         idx;
  logic signed [COEF_W-1:0]  coef_r;
  logic                      bank_r;

  logic [DIGIT_W-1:0]        digit;
  logic                      sign_ctl;
  logic signed [MULT_W-1:0]  mult_k;
  logic signed [ENT_W-1:0]   coef_x;
  logic signed [ENT_W-1:0]   mult_x;

  // multiple selected by the entry address: negative weights for the sign digit
  always_comb begin
    digit    = idx[DIGIT_W-1:0];
    sign_ctl = idx[ADDR_W-1];
    if (sign_ctl && digit[DIGIT_W-1])
      mult_k = {2'b11, digit};
    else
      mult_k = {2'b00, digit};
    coef_x = ENT_W'(coef_r);
    mult_x = ENT_W'(mult_k);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= FILL_IDLE;
      idx    <= '0;
      coef_r <= '0;
      bank_r <= 1'b0;
    end else begin
      case (state)
        FILL_IDLE: begin
          if (load_req) begin
            coef_r <= coef_in;
            idx    <= '0;
            state  <= FILL_RUN;
          end
        end
        FILL_RUN: begin
          if (idx == ADDR_W'(ENTRIES - 1)) begin
            state  <= FILL_IDLE;
            bank_r <= ~bank_r;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= FILL_IDLE;
      endcase
    end
  end

  assign wr_en     = (state == FILL_RUN);
  assign wr_bank   = ~bank_r;
  assign wr_addr   = idx;
  assign wr_data   = coef_x * mult_x;
  assign read_bank = bank_r;
  assign busy      = (state == FILL_RUN);
endmodule

// File: rtl/pp_bank_store.sv
module pp_bank_store
  import pp_tap_pkg::*;
#(
  parameter int ENT_W  = 16,
  parameter int ADDR_W = DIGIT_W + 1
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic                    wr_bank,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic signed [ENT_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic                    rd_bank,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic signed [ENT_W-1:0] rd_data
);
  localparam int ENTRIES = 2 ** ADDR_W;

  logic signed [ENT_W-1:0] q_arr [BANKS];
  logic                    rd_bank_r;

  // one simple dual-port memory per bank, registered read
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic signed [ENT_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b)))
        mem[wr_addr] <= wr_data;
      if (rd_en)
        q_arr[b] <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      rd_bank_r <= rd_bank;
  end

  assign rd_data = q_arr[rd_bank_r];
endmodule

// File: rtl/digit_serial_mac.sv
module digit_serial_mac
  import pp_tap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ENT_W  = 16,
  parameter int PROD_W = 24
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic signed [DATA_W-1:0]    data_in,
  input  logic                        bank_in,
  output logic                        rd_en,
  output logic                        rd_bank,
  output logic [DIGIT_W:0]            rd_addr,
  input  logic signed [ENT_W-1:0]     rd_data,
  output logic signed [PROD_W-1:0]    product,
  output logic                        done,
  output logic                        active,
  output logic                        cur_bank
);
  localparam int NDIG   = digits_for(DATA_W);
  localparam int EXT_W  = NDIG * DIGIT_W;
  localparam int CNT_W  = $clog2(NDIG + 1);
  localparam int ACC_W  = ENT_W + 1;
  localparam int LOW_W  = EXT_W;
  localparam int FULL_W = ACC_W + LOW_W;

  logic                     issuing;
  logic [CNT_W-1:0]         dig_cnt;
  logic [EXT_W-1:0]         sreg;
  logic                     bank_r;
  logic                     qv;
  logic                     qlast;
  logic signed [ACC_W-1:0]  acc;
  logic [LOW_W-1:0]         low_r;
  logic signed [PROD_W-1:0] product_r;
  logic                     done_r;

  logic                     idle;
  logic                     accept;
  logic                     top_dig;
  logic signed [ACC_W-1:0]  sum;
  logic signed [ACC_W-1:0]  sum_sh;
  logic [LOW_W-1:0]         low_nx;
  logic [FULL_W-1:0]        full;

  assign idle    = !issuing && !qv;
  assign accept  = start && idle;
  assign top_dig = (dig_cnt == CNT_W'(NDIG - 1));

  assign rd_en   = issuing;
  assign rd_bank = bank_r;
  assign rd_addr = {top_dig, sreg[DIGIT_W-1:0]};

  // add the new partial product, retire its three lowest bits
  always_comb begin
    sum    = acc + ACC_W'(rd_data);
    sum_sh = sum >>> DIGIT_W;
    low_nx = {sum[DIGIT_W-1:0], low_r[LOW_W-1:DIGIT_W]};
    full   = {sum_sh, low_nx};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing   <= 1'b0;
      dig_cnt   <= '0;
      sreg      <= '0;
      bank_r    <= 1'b0;
      qv        <= 1'b0;
      qlast     <= 1'b0;
      acc       <= '0;
      low_r     <= '0;
      product_r <= '0;
      done_r    <= 1'b0;
    end else begin
      done_r <= 1'b0;
      qv     <= issuing;
      qlast  <= issuing && top_dig;
      if (accept) begin
        issuing <= 1'b1;
        dig_cnt <= '0;
        sreg    <= EXT_W'(data_in);
        bank_r  <= bank_in;
        acc     <= '0;
        low_r   <= '0;
      end else if (issuing) begin
        sreg    <= sreg >> DIGIT_W;
        dig_cnt <= dig_cnt + 1'b1;
        if (top_dig)
          issuing <= 1'b0;
      end
      if (qv) begin
        acc   <= sum_sh;
        low_r <= low_nx;
        if (qlast) begin
          product_r <= full[PROD_W-1:0];
          done_r    <= 1'b1;
        end
      end
    end
  end

  assign product  = product_r;
  assign done     = done_r;
  assign active   = !idle;
  assign cur_bank = bank_r;
endmodule

// File: rtl/pp_mult_tap.sv
module pp_mult_tap
  import pp_tap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int PROD_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic signed [COEF_W-1:0] coef_in,
  input  logic                     coef_load,
  input  logic                     mul_start,
  input  logic signed [DATA_W-1:0] data_in,
  output logic signed [PROD_W-1:0] product,
  output logic                     mul_done,
  output logic                     read_bank,
  output logic                     reload_busy
);
  localparam int ADDR_W = DIGIT_W + 1;
  localparam int ENT_W  = COEF_W + DIGIT_W + 1;

  logic                    wr_en;
  logic                    wr_bank;
  logic [ADDR_W-1:0]       wr_addr;
  logic signed [ENT_W-1:0] wr_data;
  logic                    rd_en;
  logic                    rd_bank;
  logic [ADDR_W-1:0]       rd_addr;
  logic signed [ENT_W-1:0] rd_data;
  logic                    eng_active;
  logic                    eng_bank;
  logic                    load_ok;
  logic                    bank_now;

  // a load may not overwrite the table an in-flight multiply still reads
  assign load_ok = coef_load && !(eng_active && (eng_bank == ~bank_now));

  pp_table_filler #(
    .COEF_W(COEF_W), .ENT_W(ENT_W), .ADDR_W(ADDR_W)
  ) u_filler (
    .clk(clk), .rst(rst), .load_req(load_ok), .coef_in(coef_in),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .read_bank(bank_now), .busy(reload_busy)
  );

  pp_bank_store #(
    .ENT_W(ENT_W), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  digit_serial_mac #(
    .DATA_W(DATA_W), .ENT_W(ENT_W), .PROD_W(PROD_W)
  ) u_mac (
    .clk(clk), .rst(rst), .start(mul_start), .data_in(data_in),
    .bank_in(bank_now), .rd_en(rd_en), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .rd_data(rd_data), .product(product), .done(mul_done),
    .active(eng_active), .cur_bank(eng_bank)
  );

  assign read_bank = bank_now;
endmodule

// File: rtl/pp_mult_tap_chk.sv
module pp_mult_tap_chk #(
  parameter int PROD_W  = 24,
  parameter int ENTRIES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [PROD_W-1:0] product,
  input logic              mul_done,
  input logic              read_bank,
  input logic              reload_busy,
  input logic              eng_active
);
  localparam int CW = $clog2(ENTRIES + 2);

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !reload_busy) busy_cnt <= '0;
    else                     busy_cnt <= busy_cnt + 1'b1;
  end

  // R1: outputs idle after reset
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!mul_done && !reload_busy && !read_bank && product == '0));

  // R2: reload occupies exactly the table depth in cycles
  assert_reload_len_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(reload_busy) |-> (busy_cnt == CW'(ENTRIES)));

  // R2: bank changes only as a reload ends
  assert_bank_swap_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(read_bank) |-> $fell(reload_busy));

  // R5: completion is a single-cycle pulse
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    mul_done |=> !mul_done);

  // R5: product moves only with completion
  assert_product_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(product) |-> mul_done);

  // R7: engine is free again once it reports completion
  assert_free_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    mul_done |-> !eng_active);
endmodule

bind pp_mult_tap pp_mult_tap_chk #(.PROD_W(PROD_W), .ENTRIES(16)) u_chk (
  .clk(clk), .rst(rst), .product(product), .mul_done(mul_done),
  .read_bank(read_bank), .reload_busy(reload_busy), .eng_active(eng_active)
);

// File: tb/pp_mult_tap_test.sv
`timescale 1ns/1ps
module pp_mult_tap_test;
  localparam int DATA_W = 12;
  localparam int COEF_W = 12;
  localparam int PROD_W = 24;
  localparam int NDIG   = 4;

  logic                     clk = 1'b0;
  logic                     rst;
  logic signed [COEF_W-1:0] coef_in;
  logic                     coef_load;
  logic                     mul_start;
  logic signed [DATA_W-1:0] data_in;
  logic signed [PROD_W-1:0] product;
  logic                     mul_done;
  logic                     read_bank;
  logic                     reload_busy;

  int checks = 0;
  int fails  = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pp_mult_tap uut (
    .clk(clk), .rst(rst), .coef_in(coef_in), .coef_load(coef_load),
    .mul_start(mul_start), .data_in(data_in), .product(product),
    .mul_done(mul_done), .read_bank(read_bank), .reload_busy(reload_busy)
  );

  // behavioural reference
  int m_coef [2];
  int m_pend, m_rcnt, m_mcnt, m_mdata, m_prod;
  bit m_rbusy, m_bank, m_mbank, m_done;

  always @(posedge clk) begin : mdl
    bit o_rbusy, o_bank;
    int o_mcnt;
    if (rst) begin
      m_coef[0] = 0; m_coef[1] = 0; m_pend = 0; m_rcnt = 0; m_mcnt = 0;
      m_mdata = 0; m_prod = 0; m_rbusy = 0; m_bank = 0; m_mbank = 0; m_done = 0;
    end else begin
      o_rbusy = m_rbusy; o_bank = m_bank; o_mcnt = m_mcnt;
      m_done = 0;
      if (m_mcnt > 0) begin
        m_mcnt--;
        if (m_mcnt == 0) begin
          m_prod = m_mdata * m_coef[m_mbank];
          m_done = 1;
        end
      end
      if (o_rbusy) begin
        m_rcnt--;
        if (m_rcnt == 0) begin
          m_coef[!o_bank] = m_pend;
          m_bank = !o_bank;
          m_rbusy = 0;
        end
      end
      if (coef_load && !o_rbusy && !(o_mcnt > 0 && m_mbank == !o_bank)) begin
        m_rbusy = 1; m_rcnt = 16; m_pend = int'(coef_in);
      end
      if (mul_start && o_mcnt == 0) begin
        m_mcnt = NDIG + 1; m_mbank = o_bank; m_mdata = int'(data_in);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(product), m_prod, "product (R4)");
      chk(int'(mul_done), int'(m_done), "mul_done (R5)");
      chk(int'(read_bank), int'(m_bank), "read_bank (R2)");
      chk(int'(reload_busy), int'(m_rbusy), "reload_busy (R2)");
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic do_load(input int c);
    coef_in = COEF_W'(c); coef_load = 1'b1; tick(); coef_load = 1'b0;
    repeat (17) tick();
  endtask

  task automatic do_mul(input int d);
    data_in = DATA_W'(d); mul_start = 1'b1; tick(); mul_start = 1'b0;
    repeat (NDIG + 2) tick();
  endtask

  function automatic int rnd12();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    rst = 1'b1; coef_in = '0; coef_load = 1'b0; mul_start = 1'b0; data_in = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    tag = "R1";
    chk(int'(product), 0, "product after reset");
    chk(int'(read_bank), 0, "bank after reset");
    chk(int'(reload_busy), 0, "busy after reset");
    chk(int'(mul_done), 0, "done after reset");

    tag = "R2";
    do_load(5);
    chk(int'(read_bank), 1, "bank after first reload");

    tag = "R3";
    do_mul(-182);
    chk(int'(product), -910, "worked case 5 x -182");
    do_mul(-1); do_mul(7); do_mul(-512); do_mul(1755);

    tag = "R4";
    do_load(-2048);
    do_mul(-2048); do_mul(2047); do_mul(0);
    do_load(2047);
    do_mul(-2048); do_mul(2047);
    for (int i = 0; i < 30; i++) begin
      do_load(rnd12());
      do_mul(rnd12()); do_mul(rnd12()); do_mul(-2048);
    end

    tag = "R6_R8";
    do_load(77);
    coef_in = COEF_W'(-301); coef_load = 1'b1; tick(); coef_load = 1'b0;
    repeat (14) tick();
    data_in = DATA_W'(1000); mul_start = 1'b1; tick(); mul_start = 1'b0;
    tick();
    coef_in = COEF_W'(999); coef_load = 1'b1; tick(); coef_load = 1'b0;
    repeat (10) tick();
    chk(int'(reload_busy), 0, "conflicting load ignored");
    chk(int'(product), 77000, "multiply kept its starting bank");
    do_mul(3);
    chk(int'(product), -903, "new coefficient serves after swap");

    tag = "R7";
    data_in = DATA_W'(11); mul_start = 1'b1; tick();
    data_in = DATA_W'(-5); repeat (3) tick(); mul_start = 1'b0;
    repeat (NDIG + 2) tick();
    chk(int'(product), -3311, "second start ignored");

    tag = "R8";
    coef_in = COEF_W'(13); coef_load = 1'b1; tick(); coef_load = 1'b0;
    repeat (4) tick();
    coef_in = COEF_W'(-7); coef_load = 1'b1; tick(); coef_load = 1'b0;
    repeat (20) tick();
    do_mul(100);
    chk(int'(product), 1300, "load during reload ignored");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R5: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule